// File: doc/BRIEF.md
# SPI Receive Status and Interrupt Section

This block sits between the serial shift engine of an SPI peripheral and a 16-bit register bus. Each time the shift engine signals that a character has finished, the block captures the received character into a one-entry receive buffer. It keeps a buffer-full indication, a receive-ready flag and a receiver-overrun flag. It drives a single registered interrupt request that combines the receive and overrun causes.

A host reaches the block through a simple single-cycle bus. The status word at word offset 2 shows the flags. Reading the status word acknowledges the receive flag. Writing a one to the overrun bit acknowledges an overrun. The receive buffer is read at word offset 7.

An active-low soft-reset input holds the flags idle without disturbing the system reset. Two enable inputs choose which causes may raise the interrupt.

Top module: `spi_rx_status`

## Requirements
- R1: After system reset the status word (word offset 2) reads 0x0000. In the status word, bit 7 is the overrun flag, bit 6 the receive flag and bit 5 the buffer-full bit; bits 15..8 and 4..0 always read zero.
- R2: A character-done strobe (with soft reset high) stores the character, sets the buffer-full bit and sets the receive flag on the next clock. A read at word offset 7 returns the stored character in the low bits, with the upper bits zero.
- R3: Reading the status word clears the receive flag and leaves the buffer-full bit unchanged.
- R4: Reading the receive buffer clears both the receive flag and the buffer-full bit.
- R5: A character that completes while the buffer is full and is not being read in that cycle sets the overrun flag and replaces the buffered character. If the buffer is read in the same cycle, no overrun is recorded.
- R6: Writing the status word with bit 7 set clears the overrun flag. Writing bit 7 as zero, or writing any other bit, changes nothing.
- R7: When an overrun occurs in the same cycle as a write-one clear of the overrun flag, the overrun flag stays set.
- R8: An overrun request is raised only when the overrun flag goes from 0 to 1 while the overrun enable is high. Later overruns while the flag is still set raise no request, even if the enable has since gone high.
- R9: The interrupt output is registered and follows its cause by one clock. It is high while the receive flag and receive enable are both set, or while an overrun request is pending. A pending overrun request stays until the overrun flag is cleared by a write of one.
- R10: While soft reset is low, the flags and the buffer-full bit are held at zero, character strobes are ignored, and the interrupt output drops low one clock later.
- R11: With the receive enable low, the receive flag still sets but raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| soft_rst_n | input | 1 | Active-low soft reset for the flags |
| char_done | input | 1 | One-cycle strobe from the shift engine: a character has completed |
| rx_char | input | DATA_W (8) | Received character that comes with char_done |
| rx_int_en | input | 1 | Enables the receive flag as an interrupt cause |
| ovr_int_en | input | 1 | Enables the overrun flag as an interrupt cause |
| bus_sel | input | 1 | Bus access select |
| bus_rd | input | 1 | Read strobe, takes effect at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (3) | Word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for the current access |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The bench goes after the same-cycle collisions. In one, a character arrives during a buffer read; a design that checks the stale full bit would report a false overrun. In the other, a character arrives during a write-one clear; a design that lets the clear win would lose the overrun. The bench also shows that a second overrun raises no request while the flag is still set, even after the overrun enable is switched on. A design that used the level of the flag instead of its rising edge would raise the interrupt there. Finally, it checks that a pending overrun request outlives a buffer read and a write of zero, and that soft reset drops the flags and the interrupt while it ignores an arriving character.

// File: rtl/spi_rx_pkg.sv
// Shared constants and types for the SPI receive status section.
// Assumes a 16-bit register bus; status bit positions are fixed because
// host software decodes them.
package spi_rx_pkg;
    localparam int BUS_W    = 16;
    localparam int OVR_BIT  = 7;
    localparam int RXF_BIT  = 6;
    localparam int FULL_BIT = 5;

    // Snapshot of the three visible status conditions.
    typedef struct packed {
        logic ovr;
        logic rxf;
        logic full;
    } rx_stat_t;
endpackage

// File: rtl/spi_rx_buffer.sv
// One-entry receive buffer with a full indication.
// Assumes load is already qualified by soft reset. A buffer read in the same
// cycle as a load is taken as happening first, so it frees the slot for the
// new character and no overwrite is reported.
module spi_rx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] data_q,
    output logic              full_q,
    output logic              overwrite
);
    // Overwrite: a new character lands on an unread one.
    always_comb overwrite = load && full_q && !rd_ack;

    // Data capture on each accepted character.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= din;
    end

    // Full bit: set on load, cleared on read or either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n) full_q <= 1'b0;
        else if (load)             full_q <= 1'b1;
        else if (rd_ack)           full_q <= 1'b0;
    end

    assert_full_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full_q);
    assert_read_frees_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !load) |=> !full_q);
endmodule

// File: rtl/spi_rx_flags.sv
// Receive flag, overrun flag and the latched overrun interrupt request.
// Assumes strobes are single-cycle bus accesses. A new overrun beats a
// same-cycle write-one clear. The request latches only on a 0->1 flag edge.
module spi_rx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_n,
    input  logic load,
    input  logic overwrite,
    input  logic sts_rd,
    input  logic buf_rd,
    input  logic ovr_w1c,
    input  logic ovr_int_en,
    output logic rxf_q,
    output logic ovr_q,
    output logic ovr_req_q
);
    logic ovr_rise;

    // Rising edge of the overrun flag with the enable high.
    always_comb ovr_rise = overwrite && !ovr_q && ovr_int_en;

    // Receive flag: set by a load, cleared by a status or buffer read.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n)  rxf_q <= 1'b0;
        else if (load)              rxf_q <= 1'b1;
        else if (sts_rd || buf_rd)  rxf_q <= 1'b0;
    end

    // Overrun flag: the event wins over the write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n) ovr_q <= 1'b0;
        else if (overwrite)        ovr_q <= 1'b1;
        else if (ovr_w1c)          ovr_q <= 1'b0;
    end

    // Overrun request latch: armed on a first overrun, dropped by the clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n) ovr_req_q <= 1'b0;
        else if (ovr_rise)         ovr_req_q <= 1'b1;
        else if (ovr_w1c)          ovr_req_q <= 1'b0;
    end

    assert_status_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && !load) |=> !rxf_q);
    assert_overrun_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overwrite |=> ovr_q);
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_w1c && !overwrite) |=> !ovr_q);
    assert_event_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_w1c && overwrite) |=> ovr_q);
    assert_request_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_req_q) |-> ($past(!ovr_q) && ovr_q));
endmodule

// File: rtl/spi_rx_irq.sv
// Registered combined interrupt request.
// Assumes the causes come straight from flops, so the output lags them by
// one clock. It is held low while soft reset is low.
module spi_rx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_n,
    input  logic rxf,
    input  logic rx_int_en,
    input  logic ovr_req,
    output logic irq_q
);
    // Combine the enabled receive cause with the latched overrun request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= soft_rst_n && ((rxf && rx_int_en) || ovr_req);
    end

    assert_soft_reset_quiets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst_n |=> !irq_q);
    assert_pending_overrun_drives_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_req && soft_rst_n) |=> irq_q);
endmodule

// File: rtl/spi_rx_regport.sv
// Address decode and read mux for the status word and the receive buffer.
// Assumes single-cycle accesses. Reads return data in the same cycle and
// their side effects take place at the clock edge.
module spi_rx_regport
    import spi_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 3,
    parameter int STS_OFS = 2,
    parameter int BUF_OFS = 7
) (
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  rx_stat_t          stat,
    input  logic [DATA_W-1:0] buf_data,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              sts_rd,
    output logic              buf_rd,
    output logic              ovr_w1c
);
    localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(STS_OFS);
    localparam logic [ADDR_W-1:0] BUF_ADDR = ADDR_W'(BUF_OFS);

    logic sts_hit, buf_hit;
    logic unused_wdata;

    // Only bit 7 of a status write has an effect.
    always_comb unused_wdata = ^{bus_wdata[BUS_W-1:OVR_BIT+1], bus_wdata[OVR_BIT-1:0]};

    // Decode of the two word offsets and the access strobes.
    always_comb begin
        sts_hit = bus_sel && (bus_addr == STS_ADDR);
        buf_hit = bus_sel && (bus_addr == BUF_ADDR);
        sts_rd  = sts_hit && bus_rd;
        buf_rd  = buf_hit && bus_rd;
        ovr_w1c = sts_hit && bus_wr && bus_wdata[OVR_BIT];
    end

    // Read mux; reserved positions stay zero.
    always_comb begin
        bus_rdata = '0;
        if (sts_rd) begin
            bus_rdata[OVR_BIT]  = stat.ovr;
            bus_rdata[RXF_BIT]  = stat.rxf;
            bus_rdata[FULL_BIT] = stat.full;
        end else if (buf_rd) begin
            bus_rdata = BUS_W'(buf_data);
        end
    end
endmodule

// File: rtl/spi_rx_status.sv
// Top of the SPI receive status section. It ties the buffer, the flags,
// the interrupt register and the register port together. It assumes char_done
// is a one-cycle strobe in the clk domain.
module spi_rx_status
    import spi_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 3,
    parameter int STS_OFS = 2,
    parameter int BUF_OFS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_n,
    input  logic              char_done,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_int_en,
    input  logic              ovr_int_en,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq
);
    logic              load, overwrite, full_q, rxf_q, ovr_q, ovr_req_q;
    logic              sts_rd, buf_rd, ovr_w1c;
    logic [DATA_W-1:0] buf_data;
    rx_stat_t          stat;

    // Characters are accepted only outside soft reset.
    always_comb load = char_done && soft_rst_n;

    // Collect the visible status bits.
    always_comb stat = '{ovr: ovr_q, rxf: rxf_q, full: full_q};

    spi_rx_buffer #(.DATA_W(DATA_W)) u_buffer (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .load(load),
        .din(rx_char), .rd_ack(buf_rd), .data_q(buf_data), .full_q(full_q),
        .overwrite(overwrite)
    );

    spi_rx_flags u_flags (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .load(load),
        .overwrite(overwrite), .sts_rd(sts_rd), .buf_rd(buf_rd),
        .ovr_w1c(ovr_w1c), .ovr_int_en(ovr_int_en), .rxf_q(rxf_q),
        .ovr_q(ovr_q), .ovr_req_q(ovr_req_q)
    );

    spi_rx_irq u_irq (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .rxf(rxf_q),
        .rx_int_en(rx_int_en), .ovr_req(ovr_req_q), .irq_q(irq)
    );

    spi_rx_regport #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STS_OFS(STS_OFS), .BUF_OFS(BUF_OFS)
    ) u_regport (
        .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .stat(stat), .buf_data(buf_data),
        .bus_rdata(bus_rdata), .sts_rd(sts_rd), .buf_rd(buf_rd), .ovr_w1c(ovr_w1c)
    );

    assert_soft_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst_n |=> (!full_q && !rxf_q && !ovr_q));
endmodule

// File: tb/spi_rx_status_bench.sv
`timescale 1ns/1ps
module spi_rx_status_bench;
    localparam logic [2:0] OP_IDLE = 3'd0, OP_CHAR = 3'd1, OP_RDSTS = 3'd2,
                           OP_RDBUF = 3'd3, OP_W1C = 3'd4, OP_IRQ = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  d;
        logic [15:0] e;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{OP_CHAR,  8'h11, 16'h0000, 4'd2},   // R2 load
        '{OP_RDSTS, 8'h00, 16'h0060, 4'd2},   // R2 full+rxf, then R3 clears rxf
        '{OP_RDSTS, 8'h00, 16'h0020, 4'd3},   // R3 full kept
        '{OP_RDBUF, 8'h00, 16'h0011, 4'd2},   // R2 data, R4 frees
        '{OP_RDSTS, 8'h00, 16'h0000, 4'd4},   // R4
        '{OP_CHAR,  8'h22, 16'h0000, 4'd2},
        '{OP_IRQ,   8'h00, 16'h0001, 4'd9},   // R9 rxf cause
        '{OP_CHAR,  8'h33, 16'h0000, 4'd5},   // R5 overrun
        '{OP_RDSTS, 8'h00, 16'h00E0, 4'd5},
        '{OP_IRQ,   8'h00, 16'h0001, 4'd9},
        '{OP_RDBUF, 8'h00, 16'h0033, 4'd5},   // R5 new char kept
        '{OP_IRQ,   8'h00, 16'h0001, 4'd9},   // R9 overrun request held
        '{OP_W1C,   8'h7F, 16'h0000, 4'd6},   // R6 write without bit 7
        '{OP_RDSTS, 8'h00, 16'h0080, 4'd6},
        '{OP_W1C,   8'h80, 16'h0000, 4'd6},   // R6 clear
        '{OP_IRQ,   8'h00, 16'h0000, 4'd9},
        '{OP_RDSTS, 8'h00, 16'h0000, 4'd6},
        '{OP_IRQ,   8'h00, 16'h0000, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, soft_rst_n = 1'b1, char_done = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        rx_int_en = 1'b1, ovr_int_en = 1'b1;
    logic        bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    spi_rx_status u_spi_rx_status (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .char_done(char_done),
        .rx_char(rx_char), .rx_int_en(rx_int_en), .ovr_int_en(ovr_int_en),
        .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        char_done = 1'b0; bus_sel = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0;
    endtask

    // One operation occupies one clock, starting and ending at a falling edge.
    task automatic apply(input logic [2:0] op, input logic [7:0] d,
                         input logic [15:0] e, input string req);
        case (op)
            OP_CHAR:  begin char_done = 1'b1; rx_char = d; end
            OP_RDSTS: begin bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 3'd2; end
            OP_RDBUF: begin bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 3'd7; end
            OP_W1C:   begin bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd2;
                            bus_wdata = {8'h00, d}; end
            default:  ;
        endcase
        #1;
        if (op == OP_RDSTS || op == OP_RDBUF) check(req, bus_rdata, e);
        @(negedge clk);
        idle_bus();
        if (op == OP_IRQ) check(req, {15'd0, irq}, e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R9 irq at reset", {15'd0, irq}, 16'h0000);
        apply(OP_RDSTS, 8'h00, 16'h0000, "R1 reset status");

        for (int i = 0; i < NV; i++)
            apply(VEC[i].op, VEC[i].d, VEC[i].e, $sformatf("R%0d vector %0d", VEC[i].req, i));

        // R5: a character during a buffer read is no overrun.
        apply(OP_CHAR, 8'h41, 16'h0, "R5");
        char_done = 1'b1; rx_char = 8'h42; bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 3'd7;
        #1 check("R5 read sees old char", bus_rdata, 16'h0041);
        @(negedge clk); idle_bus();
        apply(OP_RDSTS, 8'h00, 16'h0060, "R5 no overrun on read collision");

        // R7: overrun and write-one clear in the same cycle.
        apply(OP_CHAR, 8'h43, 16'h0, "R7");
        apply(OP_W1C, 8'h00, 16'h0, "R7");
        char_done = 1'b1; rx_char = 8'h44; bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = 3'd2; bus_wdata = 16'h0080;
        @(negedge clk); idle_bus();
        apply(OP_RDSTS, 8'h00, 16'h00E0, "R7 flag survives clear");

        // R10: soft reset drops flags and interrupt, ignores a character.
        soft_rst_n = 1'b0; char_done = 1'b1; rx_char = 8'h55;
        @(negedge clk); idle_bus();
        apply(OP_IRQ, 8'h00, 16'h0000, "R10 irq low");
        apply(OP_RDSTS, 8'h00, 16'h0000, "R10 status cleared");
        soft_rst_n = 1'b1;
        apply(OP_RDBUF, 8'h00, 16'h0044, "R10 character ignored");

        // R8 and R11: overrun with enable low, then a later overrun.
        rx_int_en = 1'b0; ovr_int_en = 1'b0;
        apply(OP_CHAR, 8'h61, 16'h0, "R8");
        apply(OP_CHAR, 8'h62, 16'h0, "R8");
        apply(OP_IRQ, 8'h00, 16'h0000, "R11 rxf without enable");
        apply(OP_RDSTS, 8'h00, 16'h00E0, "R11 rxf still set");
        ovr_int_en = 1'b1;
        apply(OP_CHAR, 8'h63, 16'h0, "R8");
        apply(OP_IRQ, 8'h00, 16'h0000, "R8 no request while flag set");
        apply(OP_W1C, 8'h80, 16'h0, "R8");
        apply(OP_CHAR, 8'h64, 16'h0, "R8");
        apply(OP_IRQ, 8'h00, 16'h0001, "R8 request on new rise");
        apply(OP_IRQ, 8'h00, 16'h0001, "R9 request held");

        finish_run();
    end
endmodule